// File: doc/BRIEF.md
# Constant Byte Loader Sequencer

This block lets a byte-wide processor read constant data stored in its 16-bit instruction memory. A decoded load-constant instruction names a source register and a destination register. The source register holds an address into program space. A flag selects whether the upper or the lower byte of the fetched word is returned.

The block also owns the program counter. An ordinary instruction takes one cycle and moves the counter on by one. A load-constant takes two cycles:

- **Issue cycle.** The source register value drives the instruction memory address. A stall output holds the decoder. The counter keeps its value, and the destination index and byte flag are latched.
- **Write cycle.** The memory word arrives, one cycle after its address. The chosen byte is written to the destination register. The fetch address goes back to the unchanged counter, and the counter steps at the end of this cycle.

Top module: `ldc_seq`

## Requirements
- R1: While reset is low and right after it: `pc` equals `RESET_PC` (default 0), `stall` is 0, `rf_we` is 0 and `imem_addr` equals `pc`.
- R2: Outside the write cycle, `instr_valid`=1 with `instr_is_ldc`=0 makes `pc` one greater on the next cycle, with no stall and no write. `instr_valid`=0 leaves `pc` unchanged.
- R3: In the issue cycle (`instr_valid`=1, `instr_is_ldc`=1, not in a write cycle), `stall`=1, `rf_rd_idx`=`instr_src`, `imem_addr`=`rf_rd_data`, and `rf_we`=0.
- R4: `pc` does not change across the issue cycle.
- R5: The cycle after an issue cycle is the write cycle. In it, `rf_we`=1 and `rf_wr_idx` equals the `instr_dst` presented in the issue cycle.
- R6: In the write cycle, `rf_wr_data` is bits 15:8 of the word at the issued address when the latched `instr_hsel` was 1, and bits 7:0 when it was 0. Addresses 0x00 and 0xFF are both reachable.
- R7: In the write cycle, `imem_addr` equals `pc`, the counter saved at issue, and `stall` is 0.
- R8: `pc` increases by exactly one at the end of the write cycle.
- R9: Instruction inputs presented during the write cycle are ignored. They do not start a new issue and do not add an extra counter step.
- R10: A load-constant presented in the cycle right after a write cycle issues normally, so back-to-back loads each take two cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Decoded instruction present |
| instr_is_ldc | input | 1 | Instruction is a load-constant |
| instr_hsel | input | 1 | 1 = upper byte, 0 = lower byte |
| instr_src | input | IDX_W | Source (address) register index |
| instr_dst | input | IDX_W | Destination register index |
| rf_rd_idx | output | IDX_W | Register file read index |
| rf_rd_data | input | BYTE_W | Register file read data |
| rf_we | output | 1 | Register file write enable |
| rf_wr_idx | output | IDX_W | Register file write index |
| rf_wr_data | output | BYTE_W | Register file write data |
| imem_addr | output | ADDR_W | Instruction memory address |
| imem_rdata | input | WORD_W | Instruction memory data, valid one cycle after its address |
| pc | output | ADDR_W | Program counter |
| stall | output | 1 | Hold the decoder (issue cycle) |

## Verification
The bench targets the edge addresses 0x00 and 0xFF with both byte flags. If the byte lanes were swapped, or the address were truncated, the written byte would not match the memory pattern.

It changes the destination and source inputs during the write cycle. A design that reads the live index, instead of the latched one, would write the wrong register. A design that accepts a new issue there would show an extra stall and a doubled counter step.

Back-to-back loads, and a load whose address register was written by the previous load, expose a counter that steps in the issue cycle or fails to step after the write.

// File: rtl/ldc_pkg.sv
package ldc_pkg;
   typedef enum logic {
      PH_ISSUE = 1'b0,
      PH_WRITE = 1'b1
   } ldc_phase_e;
endpackage

// File: rtl/ldc_pc.sv
module ldc_pc #(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned RESET_PC = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              adv,
   output logic [ADDR_W-1:0] pc_q
);
   localparam logic [ADDR_W-1:0] RST_VAL = ADDR_W'(RESET_PC);

   always_ff @(posedge clk) begin
      if (!rst_n)   pc_q <= RST_VAL;
      else if (adv) pc_q <= pc_q + 1'b1;
   end
endmodule

// File: rtl/ldc_ctrl.sv
module ldc_ctrl
   import ldc_pkg::*;
#(
   parameter int unsigned IDX_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             instr_valid,
   input  logic             instr_is_ldc,
   input  logic             instr_hsel,
   input  logic [IDX_W-1:0] instr_dst,
   output logic             issue,
   output logic             write_ph,
   output logic             hsel_q,
   output logic [IDX_W-1:0] dst_q
);
   ldc_phase_e phase_q;

   assign write_ph = (phase_q == PH_WRITE);
   assign issue    = !write_ph && instr_valid && instr_is_ldc;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PH_ISSUE;
         hsel_q  <= 1'b0;
         dst_q   <= '0;
      end else if (issue) begin
         phase_q <= PH_WRITE;
         hsel_q  <= instr_hsel;
         dst_q   <= instr_dst;
      end else begin
         phase_q <= PH_ISSUE;
      end
   end
endmodule

// File: rtl/ldc_lane_sel.sv
module ldc_lane_sel #(
   parameter int unsigned WORD_W = 16,
   parameter int unsigned BYTE_W = 8
) (
   input  logic [WORD_W-1:0] word,
   input  logic              hsel,
   output logic [BYTE_W-1:0] lane
);
   localparam int unsigned LANES = WORD_W / BYTE_W;

   generate
      if (LANES == 1) begin : g_single
         logic unused_hsel;
         assign unused_hsel = hsel;
         assign lane        = word;
      end else begin : g_multi
         logic [BYTE_W-1:0] lanes [LANES];
         for (genvar i = 0; i < LANES; i++) begin : g_lane
            assign lanes[i] = word[i*BYTE_W +: BYTE_W];
         end
         assign lane = hsel ? lanes[LANES-1] : lanes[0];
      end
   endgenerate
endmodule

// File: rtl/ldc_seq.sv
module ldc_seq #(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned BYTE_W   = 8,
   parameter int unsigned WORD_W   = 16,
   parameter int unsigned IDX_W    = 3,
   parameter int unsigned RESET_PC = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              instr_valid,
   input  logic              instr_is_ldc,
   input  logic              instr_hsel,
   input  logic [IDX_W-1:0]  instr_src,
   input  logic [IDX_W-1:0]  instr_dst,
   output logic [IDX_W-1:0]  rf_rd_idx,
   input  logic [BYTE_W-1:0] rf_rd_data,
   output logic              rf_we,
   output logic [IDX_W-1:0]  rf_wr_idx,
   output logic [BYTE_W-1:0] rf_wr_data,
   output logic [ADDR_W-1:0] imem_addr,
   input  logic [WORD_W-1:0] imem_rdata,
   output logic [ADDR_W-1:0] pc,
   output logic              stall
);
   generate
      if (WORD_W % BYTE_W != 0) begin : g_bad_word
         $error("WORD_W must be a multiple of BYTE_W");
      end
      if (ADDR_W > BYTE_W) begin : g_bad_addr
         $error("ADDR_W cannot exceed BYTE_W");
      end
      if (IDX_W < 1) begin : g_bad_idx
         $error("IDX_W must be at least 1");
      end
   endgenerate

   logic issue, write_ph, hsel_q, adv;
   logic [IDX_W-1:0]  dst_q;
   logic [ADDR_W-1:0] pc_q;

   ldc_ctrl #(.IDX_W(IDX_W)) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .instr_valid  (instr_valid),
      .instr_is_ldc (instr_is_ldc),
      .instr_hsel   (instr_hsel),
      .instr_dst    (instr_dst),
      .issue        (issue),
      .write_ph     (write_ph),
      .hsel_q       (hsel_q),
      .dst_q        (dst_q)
   );

   assign adv = write_ph || (instr_valid && !instr_is_ldc);

   ldc_pc #(.ADDR_W(ADDR_W), .RESET_PC(RESET_PC)) u_pc (
      .clk   (clk),
      .rst_n (rst_n),
      .adv   (adv),
      .pc_q  (pc_q)
   );

   ldc_lane_sel #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_lane (
      .word (imem_rdata),
      .hsel (hsel_q),
      .lane (rf_wr_data)
   );

   assign rf_rd_idx = instr_src;
   assign rf_we     = write_ph;
   assign rf_wr_idx = dst_q;
   assign stall     = issue;
   assign pc        = pc_q;
   assign imem_addr = issue ? rf_rd_data[ADDR_W-1:0] : pc_q;
endmodule

// File: rtl/ldc_seq_chk.sv
module ldc_seq_chk #(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned BYTE_W = 8,
   parameter int unsigned IDX_W  = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              stall,
   input logic              rf_we,
   input logic [IDX_W-1:0]  instr_dst,
   input logic [IDX_W-1:0]  rf_wr_idx,
   input logic [BYTE_W-1:0] rf_rd_data,
   input logic [ADDR_W-1:0] imem_addr,
   input logic [ADDR_W-1:0] pc
);
   a_r3_addr_from_reg: assert property (@(posedge clk) disable iff (!rst_n)
      stall |-> (imem_addr == rf_rd_data[ADDR_W-1:0]));
   a_r4_pc_held: assert property (@(posedge clk) disable iff (!rst_n)
      stall |=> (pc == $past(pc)));
   a_r5_write_follows: assert property (@(posedge clk) disable iff (!rst_n)
      stall |=> rf_we);
   a_r5_dst_latched: assert property (@(posedge clk) disable iff (!rst_n)
      stall |=> (rf_wr_idx == $past(instr_dst)));
   a_r7_addr_restored: assert property (@(posedge clk) disable iff (!rst_n)
      rf_we |-> (imem_addr == pc && !stall));
   a_r8_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
      rf_we |=> (pc == $past(pc) + 1'b1));
   a_r9_no_back_write: assert property (@(posedge clk) disable iff (!rst_n)
      rf_we |=> !rf_we);
endmodule

bind ldc_seq ldc_seq_chk #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .IDX_W(IDX_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .stall      (stall),
   .rf_we      (rf_we),
   .instr_dst  (instr_dst),
   .rf_wr_idx  (rf_wr_idx),
   .rf_rd_data (rf_rd_data),
   .imem_addr  (imem_addr),
   .pc         (pc)
);

// File: tb/ldc_seq_tb.sv
module ldc_seq_tb;
   localparam int CLK_P = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       instr_valid = 1'b0, instr_is_ldc = 1'b0, instr_hsel = 1'b0;
   logic [2:0] instr_src = '0, instr_dst = '0;
   logic [2:0] rf_rd_idx, rf_wr_idx;
   logic [7:0] rf_rd_data, rf_wr_data, imem_addr, pc;
   logic       rf_we, stall;
   logic [15:0] imem_rdata = '0;
   logic [7:0] regs [8];

   int checks = 0, errors = 0;

   // Reference model state
   int         m_pc = 0;
   bit         m_phase = 0, m_hsel = 0;
   int         m_dst = 0, m_addr = 0;

   always #(CLK_P/2) clk = ~clk;

   ldc_seq u_dut (
      .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_is_ldc(instr_is_ldc),
      .instr_hsel(instr_hsel), .instr_src(instr_src), .instr_dst(instr_dst),
      .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data), .rf_we(rf_we),
      .rf_wr_idx(rf_wr_idx), .rf_wr_data(rf_wr_data), .imem_addr(imem_addr),
      .imem_rdata(imem_rdata), .pc(pc), .stall(stall)
   );

   function automatic logic [7:0] hi_of(input logic [7:0] a);
      return a * 8'd7 + 8'd3;
   endfunction
   function automatic logic [7:0] lo_of(input logic [7:0] a);
      return a ^ 8'hC3;
   endfunction

   // Memory with one-cycle read latency, and the register file
   assign rf_rd_data = regs[rf_rd_idx];
   always @(posedge clk) begin
      imem_rdata <= {hi_of(imem_addr), lo_of(imem_addr)};
      if (rf_we) regs[rf_wr_idx] <= rf_wr_data;
   end

   // Model update on each edge
   always @(posedge clk) begin
      if (!rst_n) begin
         m_pc = 0; m_phase = 0; m_hsel = 0; m_dst = 0;
      end else if (!m_phase && instr_valid && instr_is_ldc) begin
         m_phase = 1; m_dst = instr_src == instr_src ? int'(instr_dst) : 0;
         m_hsel = instr_hsel; m_addr = int'(regs[instr_src]);
      end else if (m_phase) begin
         m_phase = 0; m_pc = (m_pc + 1) % 256;
      end else if (instr_valid) begin
         m_pc = (m_pc + 1) % 256;
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic compare();
      bit iss;
      logic [7:0] wexp;
      iss = !m_phase && instr_valid && instr_is_ldc;
      wexp = m_hsel ? hi_of(8'(m_addr)) : lo_of(8'(m_addr));
      chk("R2/R4/R8 pc", int'(pc), m_pc);
      chk("R3/R7/R9 stall", int'(stall), int'(iss));
      chk("R3/R7 imem_addr", int'(imem_addr), iss ? int'(regs[instr_src]) : m_pc);
      chk("R3/R5 rf_we", int'(rf_we), int'(m_phase));
      if (m_phase) begin
         chk("R5 rf_wr_idx", int'(rf_wr_idx), m_dst);
         chk("R6 rf_wr_data", int'(rf_wr_data), int'(wexp));
      end
      if (iss) chk("R3 rf_rd_idx", int'(rf_rd_idx), int'(instr_src));
   endtask

   task automatic cyc(input bit v, input bit l, input bit h, input int s, input int d);
      @(negedge clk);
      instr_valid = v; instr_is_ldc = l; instr_hsel = h;
      instr_src = 3'(s); instr_dst = 3'(d);
      #1 compare();
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      for (int i = 0; i < 8; i++) regs[i] = 8'(i * 17);
      regs[1] = 8'h00; regs[2] = 8'hFF; regs[3] = 8'h5A;
      repeat (3) @(negedge clk);
      // R1: reset state
      #1;
      chk("R1 pc", int'(pc), 0);
      chk("R1 stall", int'(stall), 0);
      chk("R1 rf_we", int'(rf_we), 0);
      chk("R1 imem_addr", int'(imem_addr), 0);
      rst_n = 1'b1;
      cyc(0, 0, 0, 0, 0);
      // R2: ordinary instructions and idle cycles
      cyc(1, 0, 0, 0, 0);
      cyc(1, 0, 0, 0, 0);
      cyc(0, 0, 0, 0, 0);
      // R6: high byte at address 0x00, then write cycle with idle inputs
      cyc(1, 1, 1, 1, 4);
      cyc(0, 0, 0, 0, 0);
      // R6: low byte at 0x00
      cyc(1, 1, 0, 1, 5);
      cyc(0, 0, 0, 0, 0);
      // R6: both bytes at 0xFF; R10 back to back
      cyc(1, 1, 1, 2, 6);
      cyc(0, 0, 0, 0, 0);
      cyc(1, 1, 0, 2, 7);
      cyc(0, 0, 0, 0, 0);
      // R9: a load presented in the write cycle is ignored
      cyc(1, 1, 1, 3, 4);
      cyc(1, 1, 0, 2, 1);
      cyc(0, 0, 0, 0, 0);
      // R10: load whose source was written by the previous load
      cyc(1, 1, 0, 3, 1);
      cyc(1, 0, 0, 0, 0);
      cyc(1, 1, 1, 1, 2);
      cyc(1, 0, 0, 0, 0);
      cyc(1, 0, 0, 0, 0);
      // R2: many ordinary steps to wrap the counter
      for (int k = 0; k < 260; k++) cyc(1, 0, 0, 0, 0);
      cyc(1, 1, 1, 2, 3);
      cyc(0, 0, 0, 0, 0);
      cyc(0, 0, 0, 0, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule